// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable model of a synchronous burst SRAM whose read path has no output register. The word is split into two byte lanes of nine bits each, eight data bits plus one parity bit, and the array is kept small (256 words by default). Address, chip selects, strobes and write controls are captured on the rising clock edge. Read data is driven straight from the array at the registered address, so it appears in the cycle that follows the edge that accepted the command.

A new external address can be loaded by either of two strobes. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls. Between loads, an advance input steps a 2-bit burst counter through a linear or an interleaved sequence. Holding advance high instead repeats the current address as a wait state.

A snooze input and the output enable act combinationally on the output. While snooze is high, the block also ignores every clocked input. A tri-state data bus is modelled by a separate output plus an output-valid flag.

Top module: `fsb_sram_flow`

## Requirements
- R1: A synchronous reset deselects the device and forces `dataValid` low. It leaves the array contents unchanged.
- R2: The controller strobe with all three chip enables active loads `addr`. A write takes effect at that edge. A read registered at a later edge to the same address returns the new word in the cycle after that edge.
- R3: Write decode. `allWriteN` low writes both lanes. Otherwise, `byteWriteN` low writes each lane whose `laneWriteN` bit is low. Bit 0 selects lane a, which is bits [8:0]; bit 1 selects lane b, which is bits [17:9]. With no lane selected, the cycle is a read.
- R4: The processor strobe, with `chipEnN` low and the secondary enables active, loads `addr` and starts a read. It does this whatever the write controls and the controller strobe are doing.
- R5: While `chipEnN` is high, the processor strobe has no effect.
- R6: The device deselects, and `dataValid` stays low until the next accepted load, in three cases: the controller strobe arrives with `chipEnN` high; either strobe arrives with `chipEnN` low but `chipEn2N` high; or either strobe arrives with `chipEnN` low but `chipEn2` low.
- R7: With no strobe and `advanceN` low, a selected device steps its burst counter. The low two address bits follow start+k mod 4 when `interleave` was 0 at load, or start XOR k when it was 1. The upper address bits never change during a burst.
- R8: With no strobe and `advanceN` high, the registered address is reused. A write in the cycle after a processor-strobe load lands at the loaded address.
- R9: While `snooze` is high, `dataValid` is low at once, and clocked inputs change neither the state nor the array.
- R10: `dataValid` is high only while `outEnN` is low, and this takes effect combinationally. `dataOut` is zero whenever `dataValid` is low.
- R11: The chip enables are ignored on cycles that load no address, so a burst in progress continues while they are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | External word address |
| chipEnN | input | 1 | Primary chip enable, active low |
| chipEn2N | input | 1 | Secondary chip enable, active low |
| chipEn2 | input | 1 | Secondary chip enable, active high |
| procStrobeN | input | 1 | Processor-side address strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| allWriteN | input | 1 | Write both lanes, active low |
| byteWriteN | input | 1 | Enable per-lane writes, active low |
| laneWriteN | input | 2 | Per-lane write select, active low |
| outEnN | input | 1 | Output enable, active low, combinational |
| interleave | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| snooze | input | 1 | Freeze and blank the output, active high |
| dataIn | input | 18 | Write data |
| dataOut | output | 18 | Read data, zero when not valid |
| dataValid | output | 1 | Output would be driven |

## Verification
A command presented before rising edge N produces its read result during the cycle after edge N. The bench therefore drives inputs on the falling edge, lets the reference model step at the rising edge, and compares `dataValid` and `dataOut` at the next falling edge. A write accepted at edge N is observed through a read registered at edge N+1 or later. `outEnN` and `snooze` act with zero clock latency, so their checks sample one time unit after the input changes, in the middle of the low clock phase.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  // Two byte lanes, each 8 data bits plus 1 parity bit.
  localparam int FSB_LANES = 2;

  // Strobes from the control path into the address and array path.
  typedef struct packed {
    logic                 loadExt;
    logic                 advance;
    logic [FSB_LANES-1:0] wrLanes;
  } fsb_strobe_t;
endpackage

// File: rtl/fsb_ctrl.sv
module fsb_ctrl
  import fsb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 snooze,
  input  logic                 chipEnN,
  input  logic                 chipEn2N,
  input  logic                 chipEn2,
  input  logic                 procStrobeN,
  input  logic                 ctrlStrobeN,
  input  logic                 advanceN,
  input  logic                 allWriteN,
  input  logic                 byteWriteN,
  input  logic [FSB_LANES-1:0] laneWriteN,
  output fsb_strobe_t          strobe,
  output logic                 readActive
);
  logic selQ, rdQ, selD, rdD;
  logic secOk, procTake;
  logic [FSB_LANES-1:0] wrDec;
  fsb_strobe_t stb;

  always_comb begin
    wrDec = '0;
    if (!allWriteN)       wrDec = '1;
    else if (!byteWriteN) wrDec = ~laneWriteN;
    secOk    = !chipEn2N && chipEn2;
    procTake = !procStrobeN && !chipEnN;
    stb  = '0;
    selD = selQ;
    rdD  = rdQ;
    if (!snooze) begin
      if (procTake) begin
        // processor strobe: read only, write controls ignored
        if (secOk) begin
          stb.loadExt = 1'b1;
          selD = 1'b1;
          rdD  = 1'b1;
        end else begin
          selD = 1'b0;
          rdD  = 1'b0;
        end
      end else if (!ctrlStrobeN) begin
        if (!chipEnN && secOk) begin
          stb.loadExt = 1'b1;
          stb.wrLanes = wrDec;
          selD = 1'b1;
          rdD  = (wrDec == '0);
        end else begin
          selD = 1'b0;
          rdD  = 1'b0;
        end
      end else if (selQ) begin
        // continue or suspend burst; enables not sampled here
        stb.advance = !advanceN;
        stb.wrLanes = wrDec;
        rdD = (wrDec == '0);
      end
    end
    if (rst) stb.wrLanes = '0;
  end

  assign strobe = stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      selQ <= 1'b0;
      rdQ  <= 1'b0;
    end else begin
      selQ <= selD;
      rdQ  <= rdD;
    end
  end

  assign readActive = selQ && rdQ;

  // R4: accepted processor strobe always yields a read cycle
  p_proc_read_r4: assert property (@(posedge clk) disable iff (rst)
    (!snooze && !procStrobeN && !chipEnN && !chipEn2N && chipEn2) |=> readActive);

  // R6: controller strobe with primary enable high deselects
  p_ctrl_deselect_r6: assert property (@(posedge clk) disable iff (rst)
    (!snooze && !ctrlStrobeN && chipEnN) |=> !readActive);

  // R9: snooze freezes the access state
  p_snooze_hold_r9: assert property (@(posedge clk) disable iff (rst)
    snooze |=> $stable(readActive));
endmodule

// File: rtl/fsb_burst.sv
module fsb_burst
  import fsb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  fsb_strobe_t       strobe,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              interleave,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] nextAddr
);
  logic [ADDR_W-1:0]     baseQ, baseD;
  logic [BURST_BITS-1:0] cntQ, cntD;
  logic                  ilQ, ilD;

  function automatic logic [BURST_BITS-1:0] seqLo(
    input logic [BURST_BITS-1:0] startLo,
    input logic [BURST_BITS-1:0] step,
    input logic                  il
  );
    return il ? (startLo ^ step) : (startLo + step);
  endfunction

  always_comb begin
    baseD = strobe.loadExt ? extAddr : baseQ;
    ilD   = strobe.loadExt ? interleave : ilQ;
    if (strobe.loadExt)      cntD = '0;
    else if (strobe.advance) cntD = cntQ + 1'b1;
    else                     cntD = cntQ;
    curAddr  = {baseQ[ADDR_W-1:BURST_BITS], seqLo(baseQ[BURST_BITS-1:0], cntQ, ilQ)};
    nextAddr = {baseD[ADDR_W-1:BURST_BITS], seqLo(baseD[BURST_BITS-1:0], cntD, ilD)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ <= '0;
      cntQ  <= '0;
      ilQ   <= 1'b0;
    end else begin
      baseQ <= baseD;
      cntQ  <= cntD;
      ilQ   <= ilD;
    end
  end

  // R8: wait state keeps the registered address
  p_wait_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!strobe.loadExt && !strobe.advance) |=> $stable(curAddr));

  // R7: advancing never touches the upper address bits
  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && !strobe.loadExt) |=> $stable(curAddr[ADDR_W-1:BURST_BITS]));
endmodule

// File: rtl/fsb_array.sv
module fsb_array
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic                        clk,
  input  logic [FSB_LANES-1:0]        wrLanes,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [FSB_LANES*LANE_W-1:0] wrData,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [FSB_LANES*LANE_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < FSB_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (wrLanes[g]) laneMem[wrAddr] <= wrData[g*LANE_W +: LANE_W];
    end

    // flow-through: no output register
    assign rdData[g*LANE_W +: LANE_W] = laneMem[rdAddr];
  end
endmodule

// File: rtl/fsb_sram_flow.sv
module fsb_sram_flow
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        chipEnN,
  input  logic                        chipEn2N,
  input  logic                        chipEn2,
  input  logic                        procStrobeN,
  input  logic                        ctrlStrobeN,
  input  logic                        advanceN,
  input  logic                        allWriteN,
  input  logic                        byteWriteN,
  input  logic [FSB_LANES-1:0]        laneWriteN,
  input  logic                        outEnN,
  input  logic                        interleave,
  input  logic                        snooze,
  input  logic [FSB_LANES*LANE_W-1:0] dataIn,
  output logic [FSB_LANES*LANE_W-1:0] dataOut,
  output logic                        dataValid
);
  fsb_strobe_t stb;
  logic readActive;
  logic [ADDR_W-1:0] curAddr, nextAddr;
  logic [FSB_LANES*LANE_W-1:0] rdData;

  fsb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .snooze(snooze),
    .chipEnN(chipEnN), .chipEn2N(chipEn2N), .chipEn2(chipEn2),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .allWriteN(allWriteN), .byteWriteN(byteWriteN), .laneWriteN(laneWriteN),
    .strobe(stb), .readActive(readActive)
  );

  fsb_burst #(.ADDR_W(ADDR_W), .BURST_BITS(2)) u_burst (
    .clk(clk), .rst(rst), .strobe(stb), .extAddr(addr), .interleave(interleave),
    .curAddr(curAddr), .nextAddr(nextAddr)
  );

  fsb_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wrLanes(stb.wrLanes), .wrAddr(nextAddr), .wrData(dataIn),
    .rdAddr(curAddr), .rdData(rdData)
  );

  assign dataValid = readActive && !outEnN && !snooze;
  assign dataOut   = dataValid ? rdData : '0;

  // R9: no array write while snooze is high
  p_snooze_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    snooze |-> (stb.wrLanes == '0));
endmodule

// File: tb/tb_fsb_sram_flow.sv
module tb_fsb_sram_flow;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] addr = '0;
  logic chipEnN = 1'b0, chipEn2N = 1'b0, chipEn2 = 1'b1;
  logic procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advanceN = 1'b1;
  logic allWriteN = 1'b1, byteWriteN = 1'b1;
  logic [1:0] laneWriteN = 2'b11;
  logic outEnN = 1'b0, interleave = 1'b0, snooze = 1'b0;
  logic [17:0] dataIn = '0;
  logic [17:0] dataOut;
  logic dataValid;

  fsb_sram_flow dut (
    .clk(clk), .rst(rst), .addr(addr), .chipEnN(chipEnN), .chipEn2N(chipEn2N),
    .chipEn2(chipEn2), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .allWriteN(allWriteN), .byteWriteN(byteWriteN),
    .laneWriteN(laneWriteN), .outEnN(outEnN), .interleave(interleave),
    .snooze(snooze), .dataIn(dataIn), .dataOut(dataOut), .dataValid(dataValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string phase = "R1";

  // behavioural reference state
  logic [17:0] mMem [256];
  logic mSel = 1'b0, mRd = 1'b0, mIl = 1'b0;
  logic [7:0] mBase = '0;
  logic [1:0] mCnt = '0;

  function automatic logic [7:0] mAddr();
    logic [1:0] lo;
    lo = mIl ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt);
    return {mBase[7:2], lo};
  endfunction

  task automatic checkWord(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic memWrite(input logic [1:0] wl);
    logic [7:0] a;
    a = mAddr();
    if (wl[0]) mMem[a][8:0]  = dataIn[8:0];
    if (wl[1]) mMem[a][17:9] = dataIn[17:9];
  endtask

  task automatic loadModel();
    mBase = addr;
    mIl   = interleave;
    mCnt  = '0;
    mSel  = 1'b1;
  endtask

  task automatic modelStep();
    logic [1:0] wl;
    wl = !allWriteN ? 2'b11 : (!byteWriteN ? ~laneWriteN : 2'b00);
    if (rst) begin
      mSel = 1'b0; mRd = 1'b0; mCnt = '0; mBase = '0; mIl = 1'b0;
    end else if (!snooze) begin
      if (!procStrobeN && !chipEnN) begin
        if (!chipEn2N && chipEn2) begin
          loadModel();
          mRd = 1'b1;
        end else begin
          mSel = 1'b0; mRd = 1'b0;
        end
      end else if (!ctrlStrobeN) begin
        if (!chipEnN && !chipEn2N && chipEn2) begin
          loadModel();
          memWrite(wl);
          mRd = (wl == 2'b00);
        end else begin
          mSel = 1'b0; mRd = 1'b0;
        end
      end else if (mSel) begin
        if (!advanceN) mCnt = mCnt + 2'd1;
        memWrite(wl);
        mRd = (wl == 2'b00);
      end
    end
  endtask

  task automatic compareAll();
    logic expV;
    expV = mSel && mRd && !outEnN && !snooze;
    checkBit({phase, " valid"}, dataValid, expV);
    if (expV) checkWord({phase, " data"}, dataOut, mMem[mAddr()]);
    else      checkWord({phase, " blank"}, dataOut, 18'h0);
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idleIns();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1;
    allWriteN = 1'b1; byteWriteN = 1'b1; laneWriteN = 2'b11;
  endtask

  task automatic ctlOp(input logic [7:0] a, input logic gw, input logic bwe,
                       input logic [1:0] bw, input logic [17:0] d);
    idleIns();
    ctrlStrobeN = 1'b0; addr = a;
    allWriteN = gw; byteWriteN = bwe; laneWriteN = bw; dataIn = d;
    tick();
    idleIns();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [17:0] saved;
    @(negedge clk);
    // R1 reset state
    phase = "R1";
    rst = 1'b1;
    tick();
    tick();
    checkBit("R1 reset valid", dataValid, 1'b0);
    rst = 1'b0;

    // R2 write then flow-through read
    phase = "R2";
    ctlOp(8'h10, 1'b0, 1'b1, 2'b11, 18'h2A5A5);
    checkBit("R2 write cycle not valid", dataValid, 1'b0);
    ctlOp(8'h10, 1'b1, 1'b1, 2'b11, 18'h0);
    checkBit("R2 read valid", dataValid, 1'b1);
    checkWord("R2 read data", dataOut, 18'h2A5A5);

    // R3 lane decode
    phase = "R3";
    ctlOp(8'h11, 1'b0, 1'b1, 2'b11, 18'h3FFFF);
    ctlOp(8'h11, 1'b1, 1'b0, 2'b10, 18'h0);
    ctlOp(8'h11, 1'b1, 1'b1, 2'b11, 18'h0);
    checkWord("R3 lane a only", dataOut, 18'h3FE00);
    ctlOp(8'h11, 1'b1, 1'b0, 2'b01, 18'h0);
    ctlOp(8'h11, 1'b1, 1'b1, 2'b11, 18'h0);
    checkWord("R3 lane b only", dataOut, 18'h0);
    ctlOp(8'h11, 1'b1, 1'b1, 2'b00, 18'h3FFFF);
    checkBit("R3 no enable is read", dataValid, 1'b1);
    checkWord("R3 no enable no write", dataOut, 18'h0);

    // R4 processor strobe reads regardless of write controls
    phase = "R4";
    idleIns();
    procStrobeN = 1'b0; ctrlStrobeN = 1'b0; addr = 8'h10;
    allWriteN = 1'b0; dataIn = 18'h12345;
    tick();
    checkBit("R4 read valid", dataValid, 1'b1);
    checkWord("R4 old data", dataOut, 18'h2A5A5);

    // R8 write in following cycle at held address, then wait states
    phase = "R8";
    idleIns();
    allWriteN = 1'b0; dataIn = 18'h12345;
    tick();
    checkBit("R8 write cycle", dataValid, 1'b0);
    idleIns();
    tick();
    checkWord("R8 written at load address", dataOut, 18'h12345);
    tick();
    checkWord("R8 wait state repeats", dataOut, 18'h12345);

    // R5 processor strobe ignored with primary enable high
    phase = "R5";
    chipEnN = 1'b1; procStrobeN = 1'b0; addr = 8'h11;
    tick();
    checkBit("R5 still valid", dataValid, 1'b1);
    checkWord("R5 address unchanged", dataOut, 18'h12345);
    chipEnN = 1'b0; idleIns();

    // R6 deselect cases
    phase = "R6";
    chipEnN = 1'b1; ctrlStrobeN = 1'b0;
    tick();
    checkBit("R6 ctrl strobe primary high", dataValid, 1'b0);
    chipEnN = 1'b0; idleIns();
    tick();
    checkBit("R6 stays deselected", dataValid, 1'b0);
    ctlOp(8'h10, 1'b1, 1'b1, 2'b11, 18'h0);
    procStrobeN = 1'b0; chipEn2 = 1'b0;
    tick();
    checkBit("R6 proc strobe secondary low", dataValid, 1'b0);
    chipEn2 = 1'b1; idleIns();
    ctlOp(8'h10, 1'b1, 1'b1, 2'b11, 18'h0);
    ctrlStrobeN = 1'b0; chipEn2N = 1'b1;
    tick();
    checkBit("R6 ctrl strobe secondary high", dataValid, 1'b0);
    chipEn2N = 1'b0; idleIns();

    // R7 bursts: fill 0x20..0x27 linearly, read back in both orders
    phase = "R7";
    interleave = 1'b0;
    ctlOp(8'h20, 1'b0, 1'b1, 2'b11, 18'h100);
    for (int k = 1; k < 4; k++) begin
      allWriteN = 1'b0; advanceN = 1'b0; dataIn = 18'h100 + 18'(k);
      tick();
    end
    idleIns();
    ctlOp(8'h24, 1'b0, 1'b1, 2'b11, 18'h104);
    for (int k = 1; k < 4; k++) begin
      allWriteN = 1'b0; advanceN = 1'b0; dataIn = 18'h104 + 18'(k);
      tick();
    end
    idleIns();
    ctlOp(8'h22, 1'b1, 1'b1, 2'b11, 18'h0);
    checkWord("R7 linear start", dataOut, 18'h102);
    advanceN = 1'b0;
    tick(); checkWord("R7 linear +1", dataOut, 18'h103);
    tick(); checkWord("R7 linear wrap", dataOut, 18'h100);
    tick(); checkWord("R7 linear +3", dataOut, 18'h101);
    tick(); checkWord("R7 linear cycle", dataOut, 18'h102);
    idleIns();
    interleave = 1'b1;
    ctlOp(8'h25, 1'b1, 1'b1, 2'b11, 18'h0);
    interleave = 1'b0;
    checkWord("R7 interleave start", dataOut, 18'h105);
    advanceN = 1'b0;
    tick(); checkWord("R7 interleave ^1", dataOut, 18'h104);
    tick(); checkWord("R7 interleave ^2", dataOut, 18'h107);
    tick(); checkWord("R7 interleave ^3", dataOut, 18'h106);
    idleIns();

    // R11 enables not sampled during a burst
    phase = "R11";
    ctlOp(8'h20, 1'b1, 1'b1, 2'b11, 18'h0);
    chipEnN = 1'b1; chipEn2 = 1'b0; advanceN = 1'b0;
    tick();
    checkBit("R11 still valid", dataValid, 1'b1);
    checkWord("R11 burst continues", dataOut, 18'h101);
    chipEnN = 1'b0; chipEn2 = 1'b1; idleIns();

    // R10 combinational output enable
    phase = "R10";
    outEnN = 1'b1;
    #1;
    checkBit("R10 oe high blanks valid", dataValid, 1'b0);
    checkWord("R10 oe high zero data", dataOut, 18'h0);
    compareAll();
    outEnN = 1'b0;
    #1;
    checkBit("R10 oe low restores", dataValid, 1'b1);
    compareAll();

    // R9 snooze: blank now, ignore a write strobe, keep state
    phase = "R9";
    saved = dataOut;
    snooze = 1'b1;
    #1;
    checkBit("R9 snooze blanks", dataValid, 1'b0);
    ctrlStrobeN = 1'b0; addr = 8'h10; allWriteN = 1'b0; dataIn = 18'h0;
    tick();
    tick();
    idleIns();
    snooze = 1'b0;
    #1;
    checkBit("R9 valid after snooze", dataValid, 1'b1);
    checkWord("R9 address kept", dataOut, saved);
    compareAll();
    ctlOp(8'h10, 1'b1, 1'b1, 2'b11, 18'h0);
    checkWord("R9 array untouched", dataOut, 18'h12345);

    // R1 reset keeps the array
    phase = "R1";
    rst = 1'b1;
    tick();
    checkBit("R1 reset blanks", dataValid, 1'b0);
    rst = 1'b0;
    ctlOp(8'h10, 1'b1, 1'b1, 2'b11, 18'h0);
    checkWord("R1 contents retained", dataOut, 18'h12345);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule